// File: doc/BRIEF.md
# USB Host Transfer Retry Sequencer

This block carries out a single USB host transaction through the register request port of a host-side USB controller, and it keeps repeating that transaction until the controller reports success or an attempt budget runs out. When a start pulse arrives, it captures the transfer kind, the endpoint, the device address and an optional data-toggle preset. It then writes the peripheral address and, if the preset is asked for, the toggle value. Next it launches the transfer by writing a transfer-type byte. Completion is found by polling the controller. First the status byte that comes back with the launching write is examined, then the interrupt register is read until its transfer-complete flag appears.

Once the transfer has completed, the block reads the result register. A nonzero value in its low four bits marks a failed attempt, and the transfer is launched again. For OUT and IN transfers the result read is skipped when the relevant buffer flag in the interrupt byte is clear. In that case the attempt is judged by the result code the block already holds. A parameter limits the number of attempts. When the limit is reached, the run ends with a failure flag and the last result code.

The requester sees a one-cycle completion pulse, the final result code, a failure flag, the interrupt byte that signalled completion, and the send-toggle bit read back from the last result byte.

Top module: `usb_xfer_retry_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `req_valid` and `result` are all 0.
- R2: The first request of every run writes register 28 with the 7-bit device address zero-extended to 8 bits.
- R3: When `tog_load` is 1, the second request writes register 29 with 0x80 if `tog_val` is 1 and 0x40 if it is 0. When `tog_load` is 0, no write to register 29 is made.
- R4: Each attempt starts with a write to register 30. The byte written depends on `kind`. For 0 (SETUP) it is 0x10. For 1 (IN) it is the endpoint number. For 2 (OUT) it is the endpoint number ORed with 0x20. For 3 (handshake) it is 0x80, ORed with 0x20 when `hs_out` is 1.
- R5: Completion is detected from bit 7. If bit 7 of the status byte returned by the register-30 write is set, no polling takes place. Otherwise register 25 is read repeatedly until bit 7 of the read data is set. `irq_last` holds the byte that showed bit 7.
- R6: After completion, register 31 is read. If its bits 3:0 are nonzero, the register-30 write is reissued. If they are zero, the run ends with `fail` 0 and `result` 0.
- R7: The register-31 read is skipped in two cases: for OUT when bit 3 of the completion byte is clear, and for IN when bit 2 is clear. A skipped attempt is judged by the held result code, which is cleared to 0 at start.
- R8: After MAX_TRY attempts that all fail, the run ends with `fail` 1 and `result` equal to the last nonzero code. At most MAX_TRY register-30 writes are made per run.
- R9: `done` is a one-cycle pulse, and `busy` is 0 in that cycle. `tog_out` is bit 5 of the last register-31 byte read in the run, or 0 if no such read was made.
- R10: A `start` pulse while `busy` is 1 is ignored. It causes no extra request and no extra `done`.
- R11: While `req_valid` is 1 and `req_ready` is 0, the request fields stay stable and `req_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| kind | input | 2 | Transfer kind: 0 SETUP, 1 IN, 2 OUT, 3 handshake |
| hs_out | input | 1 | Handshake direction is OUT |
| endpoint | input | 4 | Endpoint number |
| dev_addr | input | 7 | Target device address |
| tog_load | input | 1 | Preset the send data toggle before the first attempt |
| tog_val | input | 1 | Toggle value to preset (1 = DATA1) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Run ended with the attempt budget exhausted |
| result | output | 4 | Final result code |
| irq_last | output | 8 | Interrupt byte that signalled completion |
| tog_out | output | 1 | Send toggle read back from the result byte |
| req_valid | output | 1 | Register request pending |
| req_ready | input | 1 | Request accepted |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 5 | Register address |
| req_wdata | output | 8 | Write data (0 for reads) |
| rsp_valid | input | 1 | Response strobe |
| rsp_status | input | 8 | Status byte returned with the command |
| rsp_rdata | input | 8 | Read data |

## Verification
The stimulus covers several cases. A SETUP transfer that completes at once tells the no-poll path apart from polling. An OUT transfer with a toggle preset, three polls and one retry separates the completion-byte source from the retry path and shows the toggle read-back. IN and OUT transfers with their buffer flags clear show that the result read is really skipped. A handshake that fails on every attempt pins down the retry limit and the failure code. A handshake that needs two attempts, with a second start pulse arriving mid-run, shows that a start while busy is ignored. Request-port stalls check that a held request does not change. The full request sequence of every run is compared entry by entry.

// File: rtl/usb_xfer_pkg.sv
// Package: shared types and controller register map for the transfer
// retry sequencer. Assumes an 8-bit register file with 5-bit addresses.
package usb_xfer_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        XK_SETUP = 2'd0,
        XK_IN    = 2'd1,
        XK_OUT   = 2'd2,
        XK_HS    = 2'd3
    } xfer_kind_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_TOG,
        S_XFER,
        S_POLL,
        S_CHECK,
        S_RES,
        S_DECIDE
    } seq_state_t;

    localparam int RA_IRQ    = 25;
    localparam int RA_DEVADR = 28;
    localparam int RA_HOSTCT = 29;
    localparam int RA_XFER   = 30;
    localparam int RA_RESULT = 31;

    localparam int BIT_DONE  = 7;
    localparam int BIT_SNDAV = 3;
    localparam int BIT_RCVAV = 2;
    localparam int BIT_TOGRD = 5;

    localparam byte_t TOG_DATA1 = 8'h80;
    localparam byte_t TOG_DATA0 = 8'h40;

endpackage

// File: rtl/usb_xfer_code.sv
// Module: builds the transfer-type byte for the launching write from
// the captured transfer kind, handshake direction and endpoint.
// Purely combinational; assumes the endpoint fits in the low nibble.
module usb_xfer_code
    import usb_xfer_pkg::*;
(
    input  xfer_kind_t kind,
    input  logic       hs_out,
    input  logic [3:0] endpoint,
    output byte_t      code
);

    // Map each kind to its transfer byte.
    always_comb begin
        case (kind)
            XK_SETUP: code = 8'h10;
            XK_IN:    code = {4'h0, endpoint};
            XK_OUT:   code = {4'h2, endpoint};
            default:  code = hs_out ? 8'hA0 : 8'h80;
        endcase
    end

endmodule

// File: rtl/usb_try_ctr.sv
// Module: attempt counter. Cleared at the start of a run, bumped on each
// retry; flags the final permitted attempt. Assumes MAX_TRY >= 1.
module usb_try_ctr #(
    parameter int MAX_TRY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic last
);

    localparam int CW = (MAX_TRY < 2) ? 1 : $clog2(MAX_TRY + 1);

    logic [CW-1:0] cnt;

    // Count attempts already retried in this run.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (bump) cnt <= cnt + 1'b1;
    end

    // Final attempt when the retried count reaches the budget minus one.
    assign last = (cnt == CW'(MAX_TRY - 1));

endmodule

// File: rtl/usb_reg_port.sv
// Module: single-outstanding register request port. Takes an issue
// strobe while idle, holds the request until accepted, then waits for the
// response and returns it with a one-cycle registered acknowledge.
module usb_reg_port
    import usb_xfer_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          iss_write,
    input  logic [AW-1:0] iss_addr,
    input  byte_t         iss_data,
    output logic          idle,
    output logic          ack,
    output byte_t         ack_status,
    output byte_t         ack_rdata,
    output logic          req_valid,
    input  logic          req_ready,
    output logic          req_write,
    output logic [AW-1:0] req_addr,
    output byte_t         req_wdata,
    input  logic          rsp_valid,
    input  byte_t         rsp_status,
    input  byte_t         rsp_rdata
);

    typedef enum logic [1:0] {P_IDLE, P_REQ, P_RSP} pst_t;

    pst_t pst;

    // Request/response handshake sequencing and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pst        <= P_IDLE;
            req_write  <= 1'b0;
            req_addr   <= '0;
            req_wdata  <= '0;
            ack        <= 1'b0;
            ack_status <= '0;
            ack_rdata  <= '0;
        end else begin
            ack <= 1'b0;
            case (pst)
                P_IDLE: if (issue) begin
                    req_write <= iss_write;
                    req_addr  <= iss_addr;
                    req_wdata <= iss_data;
                    pst       <= P_REQ;
                end
                P_REQ: if (req_ready) pst <= P_RSP;
                P_RSP: if (rsp_valid) begin
                    ack        <= 1'b1;
                    ack_status <= rsp_status;
                    ack_rdata  <= rsp_rdata;
                    pst        <= P_IDLE;
                end
                default: pst <= P_IDLE;
            endcase
        end
    end

    assign req_valid = (pst == P_REQ);
    assign idle      = (pst == P_IDLE);

endmodule

// File: rtl/usb_xfer_retry_seq.sv
// Module: transfer retry sequencer top. Writes the device address and an
// optional toggle preset, launches the transfer, polls for completion,
// reads the result code and retries up to MAX_TRY attempts.
// Assumes the controller answers every request exactly once.
module usb_xfer_retry_seq
    import usb_xfer_pkg::*;
#(
    parameter int MAX_TRY = 8,
    parameter int REG_AW  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        kind,
    input  logic              hs_out,
    input  logic [3:0]        endpoint,
    input  logic [6:0]        dev_addr,
    input  logic              tog_load,
    input  logic              tog_val,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [3:0]        result,
    output logic [7:0]        irq_last,
    output logic              tog_out,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [REG_AW-1:0] req_addr,
    output logic [7:0]        req_wdata,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_status,
    input  logic [7:0]        rsp_rdata
);

    seq_state_t state;
    xfer_kind_t kind_q;
    logic       hs_q, tload_q, tval_q;
    logic [3:0] ep_q;
    logic [6:0] addr_q;
    logic       pending;

    logic              issue, cmd_state, p_idle, p_ack;
    logic              c_write;
    logic [REG_AW-1:0] c_addr;
    byte_t             c_data, xcode, a_status, a_rdata;
    logic              try_clr, try_bump, try_last, skip_res, accept;

    usb_xfer_code u_code (
        .kind     (kind_q),
        .hs_out   (hs_q),
        .endpoint (ep_q),
        .code     (xcode)
    );

    usb_try_ctr #(.MAX_TRY(MAX_TRY)) u_try (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (try_clr),
        .bump  (try_bump),
        .last  (try_last)
    );

    usb_reg_port #(.AW(REG_AW)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (issue),
        .iss_write  (c_write),
        .iss_addr   (c_addr),
        .iss_data   (c_data),
        .idle       (p_idle),
        .ack        (p_ack),
        .ack_status (a_status),
        .ack_rdata  (a_rdata),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .rsp_rdata  (rsp_rdata)
    );

    // Select the register command that belongs to the current state.
    always_comb begin
        c_write   = 1'b0;
        c_addr    = '0;
        c_data    = '0;
        cmd_state = 1'b1;
        case (state)
            S_ADDR: begin
                c_write = 1'b1;
                c_addr  = REG_AW'(RA_DEVADR);
                c_data  = {1'b0, addr_q};
            end
            S_TOG: begin
                c_write = 1'b1;
                c_addr  = REG_AW'(RA_HOSTCT);
                c_data  = tval_q ? TOG_DATA1 : TOG_DATA0;
            end
            S_XFER: begin
                c_write = 1'b1;
                c_addr  = REG_AW'(RA_XFER);
                c_data  = xcode;
            end
            S_POLL:  c_addr = REG_AW'(RA_IRQ);
            S_RES:   c_addr = REG_AW'(RA_RESULT);
            default: cmd_state = 1'b0;
        endcase
    end

    assign issue    = cmd_state && p_idle && !pending;
    assign accept   = (state == S_IDLE) && start;
    assign try_clr  = accept;
    assign try_bump = (state == S_DECIDE) && (result != 4'd0) && !try_last;
    assign busy     = (state != S_IDLE);

    // Buffer-flag test that lets an OUT or IN attempt skip the result read.
    always_comb begin
        case (kind_q)
            XK_OUT:  skip_res = !irq_last[BIT_SNDAV];
            XK_IN:   skip_res = !irq_last[BIT_RCVAV];
            default: skip_res = 1'b0;
        endcase
    end

    // Track whether a command has been issued and not yet answered.
    always_ff @(posedge clk) begin
        if (!rst_n)     pending <= 1'b0;
        else if (issue) pending <= 1'b1;
        else if (p_ack) pending <= 1'b0;
    end

    // Main sequencing: capture at start, walk the states, update outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            kind_q   <= XK_SETUP;
            hs_q     <= 1'b0;
            ep_q     <= '0;
            addr_q   <= '0;
            tload_q  <= 1'b0;
            tval_q   <= 1'b0;
            done     <= 1'b0;
            fail     <= 1'b0;
            result   <= '0;
            irq_last <= '0;
            tog_out  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (accept) begin
                    kind_q   <= xfer_kind_t'(kind);
                    hs_q     <= hs_out;
                    ep_q     <= endpoint;
                    addr_q   <= dev_addr;
                    tload_q  <= tog_load;
                    tval_q   <= tog_val;
                    fail     <= 1'b0;
                    result   <= '0;
                    irq_last <= '0;
                    tog_out  <= 1'b0;
                    state    <= S_ADDR;
                end
                S_ADDR: if (p_ack) state <= tload_q ? S_TOG : S_XFER;
                S_TOG:  if (p_ack) state <= S_XFER;
                S_XFER: if (p_ack) begin
                    irq_last <= a_status;
                    state    <= a_status[BIT_DONE] ? S_CHECK : S_POLL;
                end
                S_POLL: if (p_ack) begin
                    irq_last <= a_rdata;
                    if (a_rdata[BIT_DONE]) state <= S_CHECK;
                end
                S_CHECK: state <= skip_res ? S_DECIDE : S_RES;
                S_RES: if (p_ack) begin
                    result  <= a_rdata[3:0];
                    tog_out <= a_rdata[BIT_TOGRD];
                    state   <= S_DECIDE;
                end
                S_DECIDE: begin
                    if (result == 4'd0) begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else if (try_last) begin
                        done  <= 1'b1;
                        fail  <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        state <= S_XFER;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/usb_xfer_retry_seq_chk.sv
// Module: protocol checker for the transfer retry sequencer, attached
// to every instance of the top by the bind below. Counts launching
// writes per run to bound the attempt budget.
module usb_xfer_retry_seq_chk #(
    parameter int MAX_TRY = 8,
    parameter int REG_AW  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [3:0]        result,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [REG_AW-1:0] req_addr,
    input logic [7:0]        req_wdata
);

    localparam int CW = $clog2(MAX_TRY + 2);

    logic [CW-1:0] launches;

    // Launching writes seen since the run began.
    always_ff @(posedge clk) begin
        if (!rst_n)
            launches <= '0;
        else if (start && !busy)
            launches <= '0;
        else if (req_valid && req_ready && req_write && req_addr == REG_AW'(30))
            launches <= launches + 1'b1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid); // R1
    AST_SUCCESS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (result == 4'd0)); // R6
    AST_FAIL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (result != 4'd0)); // R8
    AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        launches <= CW'(MAX_TRY)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                       && $stable(req_write) && $stable(req_wdata))); // R11

endmodule

bind usb_xfer_retry_seq usb_xfer_retry_seq_chk #(
    .MAX_TRY (MAX_TRY),
    .REG_AW  (REG_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .result    (result),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata)
);

// File: tb/usb_xfer_retry_seq_bench.sv
module usb_xfer_retry_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TRIES      = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] kind = 2'd0;
    logic       hs_out = 1'b0;
    logic [3:0] endpoint = 4'd0;
    logic [6:0] dev_addr = 7'd0;
    logic       tog_load = 1'b0;
    logic       tog_val = 1'b0;
    logic       busy, done, fail, tog_out;
    logic [3:0] result;
    logic [7:0] irq_last;
    logic       req_valid, req_write;
    logic       req_ready = 1'b0;
    logic [4:0] req_addr;
    logic [7:0] req_wdata;
    logic       rsp_valid = 1'b0;
    logic [7:0] rsp_status = 8'h00;
    logic [7:0] rsp_rdata = 8'h00;

    usb_xfer_retry_seq #(.MAX_TRY(TRIES), .REG_AW(5)) u_usb_xfer_retry_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .hs_out(hs_out),
        .endpoint(endpoint), .dev_addr(dev_addr), .tog_load(tog_load),
        .tog_val(tog_val), .busy(busy), .done(done), .fail(fail),
        .result(result), .irq_last(irq_last), .tog_out(tog_out),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_rdata(rsp_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Controller model state and scripts.
    logic [7:0] xs [8];
    logic [7:0] pl [8];
    logic [7:0] rs [8];
    int xi, pi, ri, stall, stall_cnt, phase;
    logic       lg_w [32];
    int         lg_a [32];
    int         lg_d [32];
    int         log_n, done_cnt;
    bit         hold_bad;
    logic [4:0] h_a;
    logic [7:0] h_d, nxt_st, nxt_rd;
    logic       h_w;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Register-controller model, driven away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            phase = 0; req_ready = 1'b0; rsp_valid = 1'b0; stall_cnt = 0;
        end else begin
            case (phase)
                0: if (req_valid) begin
                    if (stall_cnt == 0) begin
                        h_a = req_addr; h_w = req_write; h_d = req_wdata;
                    end else if (req_addr != h_a || req_write != h_w || req_wdata != h_d) begin
                        hold_bad = 1'b1;
                    end
                    if (stall_cnt < stall) begin
                        stall_cnt++;
                        req_ready = 1'b0;
                    end else begin
                        req_ready = 1'b1;
                        stall_cnt = 0;
                        if (log_n < 32) begin
                            lg_w[log_n] = req_write;
                            lg_a[log_n] = int'(req_addr);
                            lg_d[log_n] = int'(req_wdata);
                        end
                        log_n++;
                        nxt_st = 8'h00; nxt_rd = 8'h00;
                        if (req_write && req_addr == 5'd30) begin
                            nxt_st = xs[xi % 8]; xi++;
                        end else if (!req_write && req_addr == 5'd25) begin
                            nxt_rd = pl[pi % 8]; pi++;
                        end else if (!req_write && req_addr == 5'd31) begin
                            nxt_rd = rs[ri % 8]; ri++;
                        end
                        phase = 1;
                    end
                end
                1: begin
                    req_ready = 1'b0; rsp_valid = 1'b1;
                    rsp_status = nxt_st; rsp_rdata = nxt_rd; phase = 2;
                end
                default: begin
                    rsp_valid = 1'b0; phase = 0;
                end
            endcase
            if (done) done_cnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_log(input int i, input bit w, input int a, input int d,
                           input string tag);
        int act, exp;
        exp = (int'(w) << 16) | (a << 8) | d;
        act = (i < log_n && i < 32) ? ((int'(lg_w[i]) << 16) | (lg_a[i] << 8) | lg_d[i]) : -1;
        chk(act == exp, tag, $sformatf("request %0d", i), act, exp);
    endtask

    task automatic clear_run();
        for (int i = 0; i < 8; i++) begin xs[i] = 8'h80; pl[i] = 8'h80; rs[i] = 8'h00; end
        xi = 0; pi = 0; ri = 0; log_n = 0; done_cnt = 0; hold_bad = 1'b0; stall = 0;
    endtask

    task automatic start_xfer(input int k, input bit h, input int ep, input int a,
                              input bit tl, input bit tv);
        @(negedge clk);
        kind = 2'(k); hs_out = h; endpoint = 4'(ep); dev_addr = 7'(a);
        tog_load = tl; tog_val = tv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n;
        n = 0;
        while (done_cnt == 0 && n < 3000) begin @(negedge clk); n++; end
        chk(done_cnt != 0, tag, "done seen", done_cnt, 1);
        repeat (20) @(negedge clk);
        chk(done_cnt == 1 && !busy, tag, "single done pulse, idle", done_cnt, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !done && !fail && !req_valid && result == 4'd0, "R1",
            "reset outputs", {busy, done, fail, req_valid, result}, 0);
    endtask

    task automatic t_setup_fast();
        clear_run();
        rs[0] = 8'h00;
        start_xfer(0, 1'b0, 0, 5, 1'b0, 1'b0);
        wait_done("R5");
        chk_log(0, 1'b1, 28, 8'h05, "R2");
        chk_log(1, 1'b1, 30, 8'h10, "R4");
        chk_log(2, 1'b0, 31, 0, "R6");
        chk(log_n == 3, "R5", "no poll reads", log_n, 3);
        chk(!fail && result == 4'd0 && irq_last == 8'h80, "R6", "setup outcome",
            {fail, result, irq_last}, 12'h080);
    endtask

    task automatic t_out_poll_retry();
        clear_run();
        stall = 2;
        xs[0] = 8'h00; xs[1] = 8'h88;
        pl[0] = 8'h00; pl[1] = 8'h00; pl[2] = 8'h88;
        rs[0] = 8'h24; rs[1] = 8'h20;
        start_xfer(2, 1'b0, 2, 7'h11, 1'b1, 1'b1);
        wait_done("R6");
        chk_log(0, 1'b1, 28, 8'h11, "R2");
        chk_log(1, 1'b1, 29, 8'h80, "R3");
        chk_log(2, 1'b1, 30, 8'h22, "R4");
        chk_log(3, 1'b0, 25, 0, "R5");
        chk_log(4, 1'b0, 25, 0, "R5");
        chk_log(5, 1'b0, 25, 0, "R5");
        chk_log(6, 1'b0, 31, 0, "R6");
        chk_log(7, 1'b1, 30, 8'h22, "R6");
        chk_log(8, 1'b0, 31, 0, "R6");
        chk(log_n == 9, "R6", "request count", log_n, 9);
        chk(!fail && result == 4'd0 && irq_last == 8'h88, "R5", "out outcome",
            {fail, result, irq_last}, 12'h088);
        chk(tog_out == 1'b1, "R9", "toggle readback", tog_out, 1);
        chk(!hold_bad, "R11", "request stable while stalled", hold_bad, 0);
    endtask

    task automatic t_in_skip();
        clear_run();
        xs[0] = 8'h80;
        rs[0] = 8'h07;
        start_xfer(1, 1'b0, 3, 9, 1'b1, 1'b0);
        wait_done("R7");
        chk_log(1, 1'b1, 29, 8'h40, "R3");
        chk_log(2, 1'b1, 30, 8'h03, "R4");
        chk(log_n == 3, "R7", "IN result read skipped", log_n, 3);
        chk(!fail && result == 4'd0 && tog_out == 1'b0, "R7", "IN skip outcome",
            {fail, result, tog_out}, 0);
    endtask

    task automatic t_out_skip();
        clear_run();
        xs[0] = 8'h84;
        rs[0] = 8'h03;
        start_xfer(2, 1'b0, 1, 3, 1'b0, 1'b0);
        wait_done("R7");
        chk_log(0, 1'b1, 28, 8'h03, "R2");
        chk_log(1, 1'b1, 30, 8'h21, "R3");
        chk(log_n == 2, "R7", "OUT result read skipped", log_n, 2);
        chk(!fail && result == 4'd0 && irq_last == 8'h84, "R7", "OUT skip outcome",
            {fail, result, irq_last}, 12'h084);
    endtask

    task automatic t_hs_exhaust();
        clear_run();
        for (int i = 0; i < 8; i++) rs[i] = 8'h05;
        start_xfer(3, 1'b1, 0, 2, 1'b0, 1'b0);
        wait_done("R8");
        chk_log(1, 1'b1, 30, 8'hA0, "R4");
        chk_log(3, 1'b1, 30, 8'hA0, "R8");
        chk_log(5, 1'b1, 30, 8'hA0, "R8");
        chk_log(6, 1'b0, 31, 0, "R8");
        chk(log_n == 1 + 2 * TRIES, "R8", "attempt budget", log_n, 1 + 2 * TRIES);
        chk(fail && result == 4'd5, "R8", "fail with last code", {fail, result}, 8'h15);
    endtask

    task automatic t_busy_start();
        clear_run();
        rs[0] = 8'h0E; rs[1] = 8'h00;
        start_xfer(3, 1'b0, 0, 4, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        kind = 2'd0; dev_addr = 7'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R10");
        chk_log(0, 1'b1, 28, 8'h04, "R10");
        chk_log(1, 1'b1, 30, 8'h80, "R4");
        chk_log(3, 1'b1, 30, 8'h80, "R6");
        chk(log_n == 5, "R10", "no extra requests", log_n, 5);
        chk(!fail && result == 4'd0, "R6", "handshake retry outcome", {fail, result}, 0);
    endtask

    initial begin
        clear_run();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_setup_fast();
        t_out_poll_retry();
        t_in_skip();
        t_out_skip();
        t_hs_exhaust();
        t_busy_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule